// File: doc/BRIEF.md
# Status Frame Validator and Forwarder

This block listens on a single serial line for 16-bit status frames. A frame is sent least significant bit first, framed by a low start bit and a high stop bit, and the line rests high between frames. Each frame is sampled at the middle of every bit. A frame is trusted only when its stop bit and its bit 0 (an always-one marker) are both high. Any other frame is dropped.

A new status value is accepted only after two identical trusted frames arrive one after the other. On each accepted change, the upper byte (bits 15:8, the targets and trip release code) is handed to a downstream controller as a one-cycle strobe with data. While the status stays the same, the same byte is handed over again on every tenth unchanged frame, so the downstream side cannot miss a change for long.

The block also raises a chassis alarm in two cases: when no trusted frame has arrived for the timeout window (600 ms at the default clock), or when a configuration jumper input changes. The alarm comes with a one-shot request to send an alarm message. The first trusted frame that arrives while the alarm is up drops the alarm and gives a one-shot clear request.

Top module: `spm_status_monitor`

## Requirements
- R1: The receiver treats `rx_line` as idle high. It passes the line through a two-flop synchronizer. After a low level it checks the start bit at mid-bit. It then samples 16 data bits, bit 0 first, and one stop bit, each `CLKS_PER_BIT` clocks long and each sampled at its middle.
- R2: A frame is valid only if its stop bit is 1 and its data bit 0 is 1. An invalid frame does not change `status_word`, does not raise `fwd_stb`, does not take part in pairing and does not restart the timeout.
- R3: `status_word` takes a new value, and `status_valid` goes to 1, only when two back-to-back valid frames carry the same value and that value differs from the current `status_word` (or no value has been accepted yet).
- R4: In the cycle after a change is accepted, `fwd_stb` is 1 for exactly one cycle and `fwd_byte` equals bits 15:8 of the accepted word.
- R5: A valid frame equal to both the previous valid frame and `status_word` is an unchanged frame. On the `REFRESH_FRAMES`-th (default 10) unchanged frame, `fwd_stb` pulses with bits 15:8. The count of unchanged frames restarts at zero on each accepted change and on each refresh.
- R6: If `TIMEOUT_CLKS` clocks pass without a valid frame, `alarm` goes to 1. It does not go to 1 earlier than that.
- R7: A change in level of `jumper_in`, once it has passed its synchronizer, sets `alarm` to 1.
- R8: `alarm_msg` pulses for one cycle only when `alarm` goes from 0 to 1. A further cause while `alarm` is already 1 gives no new pulse.
- R9: The first valid frame seen while `alarm` is 1 clears `alarm` and pulses `alarm_clr` for one cycle.
- R10: After reset, `status_word` = 0, `status_valid` = 0, `fwd_stb` = 0, `alarm_msg` = 0, `alarm_clr` = 0 and `alarm` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial status line, idle high |
| jumper_in | input | 1 | Configuration jumper level |
| status_word | output | 16 | Last accepted status word |
| status_valid | output | 1 | A status word has been accepted since reset |
| fwd_stb | output | 1 | One-cycle strobe: forward `fwd_byte` downstream |
| fwd_byte | output | 8 | Upper status byte to forward |
| alarm | output | 1 | Chassis alarm level |
| alarm_msg | output | 1 | One-cycle request to send the alarm message |
| alarm_clr | output | 1 | One-cycle request to send the alarm-clear message |

## Verification
The pairing logic is driven with a sequence of frames. The sequence includes a first frame followed by its repeat, a new value seen only once, a frame with a cleared marker and a frame with a low stop bit, each placed between two frames that would otherwise pair. It also includes a single different frame inserted into a run of identical ones. This separates a true back-to-back match from a match that survives a dropped frame, and shows that dropped frames never become the pairing reference. A long run of unchanged frames is placed so that a refresh happens on the tenth frame only. In a second run, a change is accepted partway through the count, which shows whether the counter is really restarted. Silence, a flood of invalid frames and jumper toggles, each given with the alarm already up and with it down, separate the timeout and jumper causes from the one-shot message behaviour.

// File: rtl/spm_pkg.sv
// Shared definitions for the status monitor.
// Assumes 16-bit frames whose upper byte is the forwarded part.
package spm_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/spm_serial_rx.sv
// Serial frame receiver: a start bit (low), WORD_W data bits (bit 0 first)
// and one stop bit. It synchronizes the line and samples each bit at mid-bit.
// Assumes CLKS_PER_BIT >= 4 and an idle-high line. It pulses done_o for one
// cycle with the frame and its stop bit, whether the stop bit is good or not.
module spm_serial_rx
    import spm_pkg::*;
#(
    parameter int CLKS_PER_BIT = 2500
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_i,
    output word_t frame_o,
    output logic  stop_o,
    output logic  done_o
);
    localparam int TICK_W = $clog2(CLKS_PER_BIT + 1);
    localparam int IDX_W  = $clog2(WORD_W + 1);
    localparam int HALF   = CLKS_PER_BIT / 2;

    logic [1:0]       sync_q;
    rx_state_e        state_q;
    logic [TICK_W-1:0] tick_q;
    logic [IDX_W-1:0]  idx_q;
    word_t            shift_q;
    logic             stop_q;
    logic             done_q;
    logic             line_s;
    logic             bit_end;

    assign line_s  = sync_q[1];
    assign bit_end = (tick_q == TICK_W'(CLKS_PER_BIT - 1));

    // Two-flop synchronizer for the asynchronous line, reset to idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Frame state machine: start check, data shift, stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tick_q  <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            stop_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    tick_q <= '0;
                    if (!line_s) state_q <= RX_START;
                end
                RX_START: begin
                    if (tick_q == TICK_W'(HALF - 1)) begin
                        tick_q <= '0;
                        idx_q  <= '0;
                        state_q <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        tick_q  <= '0;
                        shift_q <= {line_s, shift_q[WORD_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == IDX_W'(WORD_W - 1)) state_q <= RX_STOP;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        tick_q  <= '0;
                        stop_q  <= line_s;
                        done_q  <= 1'b1;
                        state_q <= RX_IDLE;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign frame_o = shift_q;
    assign stop_o  = stop_q;
    assign done_o  = done_q;

    // R1: the bit index never runs past the frame length.
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(WORD_W))
        else $error("bit index out of range");

    // R1: a frame completes only out of the stop-bit state.
    p_done_from_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(state_q) == RX_STOP))
        else $error("frame done outside stop state");
endmodule

// File: rtl/spm_frame_filter.sv
// Frame qualifier and debounce. It keeps only frames with a good stop bit and
// a set marker bit. It accepts a new word after two identical frames in a
// row and forwards the upper byte on each accept and on every
// REFRESH_FRAMES-th unchanged frame.
// Assumes frame_i is stable while done_i is high.
module spm_frame_filter
    import spm_pkg::*;
#(
    parameter int REFRESH_FRAMES = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t frame_i,
    input  logic  stop_i,
    input  logic  done_i,
    output logic  good_o,
    output word_t word_o,
    output logic  word_vld_o,
    output logic  fwd_stb_o,
    output byte_t fwd_byte_o
);
    localparam int CNT_W = $clog2(REFRESH_FRAMES + 1);

    word_t            prev_q;
    logic             prev_vld_q;
    word_t            word_q;
    logic             word_vld_q;
    logic [CNT_W-1:0] same_q;
    logic             fwd_q;
    byte_t            byte_q;
    logic             good;
    logic             pair;
    logic             changed;

    assign good    = done_i && stop_i && frame_i[0];
    assign pair    = prev_vld_q && (frame_i == prev_q);
    assign changed = !word_vld_q || (frame_i != word_q);

    // Pairing, acceptance and refresh counting on each good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
            word_q     <= '0;
            word_vld_q <= 1'b0;
            same_q     <= '0;
            fwd_q      <= 1'b0;
            byte_q     <= '0;
        end else begin
            fwd_q <= 1'b0;
            if (good) begin
                prev_q     <= frame_i;
                prev_vld_q <= 1'b1;
                if (pair) begin
                    if (changed) begin
                        word_q     <= frame_i;
                        word_vld_q <= 1'b1;
                        same_q     <= '0;
                        fwd_q      <= 1'b1;
                        byte_q     <= frame_i[WORD_W-1 -: BYTE_W];
                    end else if (same_q == CNT_W'(REFRESH_FRAMES - 1)) begin
                        same_q <= '0;
                        fwd_q  <= 1'b1;
                        byte_q <= frame_i[WORD_W-1 -: BYTE_W];
                    end else begin
                        same_q <= same_q + 1'b1;
                    end
                end
            end
        end
    end

    assign good_o     = good;
    assign word_o     = word_q;
    assign word_vld_o = word_vld_q;
    assign fwd_stb_o  = fwd_q;
    assign fwd_byte_o = byte_q;

    // R3: the accepted word only moves in the cycle after a good frame.
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> $stable(word_q))
        else $error("accepted word moved without a good frame");

    // R4: a forward always carries the upper byte of an accepted word.
    p_fwd_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q |-> (word_vld_q && byte_q == word_q[WORD_W-1 -: BYTE_W]))
        else $error("forwarded byte does not match accepted word");

    // R5: the unchanged-frame count stays below the refresh period.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        same_q < CNT_W'(REFRESH_FRAMES))
        else $error("refresh counter overran");
endmodule

// File: rtl/spm_link_watch.sv
// Chassis alarm supervisor. It raises the alarm when no good frame has
// arrived for TIMEOUT_CLKS clocks or when the synchronized jumper level
// changes. A good frame while the alarm is up clears it. One-shot message
// and clear strobes mark the edges.
// Assumes the jumper input is quasi-static and may be asynchronous.
module spm_link_watch #(
    parameter int TIMEOUT_CLKS = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good_i,
    input  logic jumper_i,
    output logic alarm_o,
    output logic msg_o,
    output logic clr_o
);
    localparam int TMR_W = $clog2(TIMEOUT_CLKS + 1);

    logic [TMR_W-1:0] timer_q;
    logic [1:0]       jsync_q;
    logic             jref_q;
    logic [1:0]       arm_q;
    logic             alarm_q;
    logic             msg_q;
    logic             clr_q;
    logic             expired;
    logic             armed;
    logic             jchange;
    logic             raise;

    assign expired = (timer_q == TMR_W'(TIMEOUT_CLKS - 1));
    assign armed   = (arm_q == 2'd3);
    assign jchange = armed && (jsync_q[1] != jref_q);
    assign raise   = jchange || (expired && !good_i);

    // Silence timer: restarts on a good frame, holds once expired.
    always_ff @(posedge clk) begin
        if (!rst_n)        timer_q <= '0;
        else if (good_i)   timer_q <= '0;
        else if (!expired) timer_q <= timer_q + 1'b1;
    end

    // Jumper synchronizer and reference; compares only once the pipe is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jsync_q <= 2'b00;
            jref_q  <= 1'b0;
            arm_q   <= 2'd0;
        end else begin
            jsync_q <= {jsync_q[0], jumper_i};
            jref_q  <= jsync_q[1];
            if (!armed) arm_q <= arm_q + 1'b1;
        end
    end

    // Alarm level with one-shot raise and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b1;
            msg_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            msg_q <= 1'b0;
            clr_q <= 1'b0;
            if (raise) begin
                alarm_q <= 1'b1;
                msg_q   <= !alarm_q;
            end else if (good_i && alarm_q) begin
                alarm_q <= 1'b0;
                clr_q   <= 1'b1;
            end
        end
    end

    assign alarm_o = alarm_q;
    assign msg_o   = msg_q;
    assign clr_o   = clr_q;

    // R8: the message request comes only on a 0 to 1 alarm edge.
    p_msg_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_q |-> (alarm_q && !$past(alarm_q)))
        else $error("alarm message without alarm rise");

    // R9: the clear request comes only on a 1 to 0 alarm edge.
    p_clr_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (!alarm_q && $past(alarm_q)))
        else $error("alarm clear without alarm fall");

    // R8: the two strobes never fire together.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({msg_q, clr_q}) <= 1)
        else $error("message and clear strobes together");

    // R6: the silence timer never passes its limit.
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= TMR_W'(TIMEOUT_CLKS - 1))
        else $error("silence timer overran");
endmodule

// File: rtl/spm_status_monitor.sv
// Top of the status monitor: serial receiver, frame filter and alarm
// supervisor. Defaults assume a 250 MHz clock, 100 kbit/s frames and a
// 600 ms silence window.
module spm_status_monitor #(
    parameter int CLKS_PER_BIT   = 2500,
    parameter int REFRESH_FRAMES = 10,
    parameter int TIMEOUT_CLKS   = 150_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line,
    input  logic        jumper_in,
    output logic [15:0] status_word,
    output logic        status_valid,
    output logic        fwd_stb,
    output logic [7:0]  fwd_byte,
    output logic        alarm,
    output logic        alarm_msg,
    output logic        alarm_clr
);
    spm_pkg::word_t rx_frame;
    logic           rx_stop;
    logic           rx_done;
    logic           good;

    spm_serial_rx #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .frame_o(rx_frame),
        .stop_o (rx_stop),
        .done_o (rx_done)
    );

    spm_frame_filter #(
        .REFRESH_FRAMES(REFRESH_FRAMES)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (rx_frame),
        .stop_i    (rx_stop),
        .done_i    (rx_done),
        .good_o    (good),
        .word_o    (status_word),
        .word_vld_o(status_valid),
        .fwd_stb_o (fwd_stb),
        .fwd_byte_o(fwd_byte)
    );

    spm_link_watch #(
        .TIMEOUT_CLKS(TIMEOUT_CLKS)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .good_i  (good),
        .jumper_i(jumper_in),
        .alarm_o (alarm),
        .msg_o   (alarm_msg),
        .clr_o   (alarm_clr)
    );

    // R2: a good frame always has its marker and stop bits set.
    p_good_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> (rx_done && rx_stop && rx_frame[0]))
        else $error("good frame without marker or stop");
endmodule

// File: tb/spm_status_monitor_test.sv
`timescale 1ns/1ps
module spm_status_monitor_test;
    localparam int BIT_CLKS = 8;
    localparam int TMO      = 2000;
    localparam int GAP      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        jumper_in = 1'b0;
    logic [15:0] status_word;
    logic        status_valid;
    logic        fwd_stb;
    logic [7:0]  fwd_byte;
    logic        alarm;
    logic        alarm_msg;
    logic        alarm_clr;

    int checks = 0;
    int fails  = 0;
    int fwd_cnt = 0;
    int msg_cnt = 0;
    int clr_cnt = 0;
    logic [7:0] last_byte = 8'h00;

    always #2 clk = ~clk;

    spm_status_monitor #(
        .CLKS_PER_BIT  (BIT_CLKS),
        .REFRESH_FRAMES(10),
        .TIMEOUT_CLKS  (TMO)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .jumper_in   (jumper_in),
        .status_word (status_word),
        .status_valid(status_valid),
        .fwd_stb     (fwd_stb),
        .fwd_byte    (fwd_byte),
        .alarm       (alarm),
        .alarm_msg   (alarm_msg),
        .alarm_clr   (alarm_clr)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fwd_stb) begin
                fwd_cnt++;
                last_byte = fwd_byte;
            end
            if (alarm_msg) msg_cnt++;
            if (alarm_clr) clr_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [15:0] d, input logic stop);
        @(posedge clk); #1;
        rx_line = 1'b0;
        repeat (BIT_CLKS) @(posedge clk);
        #1;
        for (int i = 0; i < 16; i++) begin
            rx_line = d[i];
            repeat (BIT_CLKS) @(posedge clk);
            #1;
        end
        rx_line = stop;
        repeat (BIT_CLKS) @(posedge clk);
        #1;
        rx_line = 1'b1;
        repeat (GAP) @(posedge clk);
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [15:0] frame;
        logic        stop;
        logic [15:0] exp_word;
        logic        exp_vld;
        logic        exp_fwd;
        logic [7:0]  exp_byte;
        logic        exp_alarm;
        logic        exp_clr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'h12A1, 1'b1, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // first frame clears alarm (R9)
        '{16'h12A1, 1'b1, 16'h12A1, 1'b1, 1'b1, 8'h12, 1'b0, 1'b0}, // pair accepted (R3, R4)
        '{16'h34C1, 1'b1, 16'h12A1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // single new value held off
        '{16'h34C0, 1'b1, 16'h12A1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // marker clear dropped (R2)
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b1, 8'h34, 1'b0, 1'b0}, // pairs across dropped frame
        '{16'h56E1, 1'b0, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // bad stop dropped (R2)
        '{16'h56E1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // bad-stop frame not a reference
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // glitch broke the pair
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // unchanged 1
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 2
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 3
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 4
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 5
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 6
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 7
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 8
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // 9
        '{16'h34C1, 1'b1, 16'h34C1, 1'b1, 1'b1, 8'h34, 1'b0, 1'b0}  // 10th: refresh (R5)
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int f0;
        int m0;
        int c0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);

        // R10: reset state
        chk("R10 word",  32'(status_word), 32'h0);
        chk("R10 valid", 32'(status_valid), 32'h0);
        chk("R10 alarm", 32'(alarm), 32'h1);
        chk("R10 strobes", 32'(fwd_cnt + msg_cnt + clr_cnt), 32'h0);

        // Vector table: R1, R2, R3, R4, R5, R9
        for (int v = 0; v < NV; v++) begin
            f0 = fwd_cnt;
            c0 = clr_cnt;
            send_frame(VECS[v].frame, VECS[v].stop);
            chk($sformatf("R3 word v%0d", v), 32'(status_word), 32'(VECS[v].exp_word));
            chk($sformatf("R3 valid v%0d", v), 32'(status_valid), 32'(VECS[v].exp_vld));
            chk($sformatf("R4/R5 fwd v%0d", v), 32'(fwd_cnt - f0), 32'(VECS[v].exp_fwd));
            if (VECS[v].exp_fwd)
                chk($sformatf("R4 byte v%0d", v), 32'(last_byte), 32'(VECS[v].exp_byte));
            chk($sformatf("R9 alarm v%0d", v), 32'(alarm), 32'(VECS[v].exp_alarm));
            chk($sformatf("R9 clr v%0d", v), 32'(clr_cnt - c0), 32'(VECS[v].exp_clr));
        end

        // R5: an accepted change restarts the unchanged-frame count
        f0 = fwd_cnt;
        for (int i = 0; i < 5; i++) send_frame(16'h34C1, 1'b1);
        chk("R5 no early refresh", 32'(fwd_cnt - f0), 32'h0);
        send_frame(16'h7801, 1'b1);
        send_frame(16'h7801, 1'b1);
        chk("R4 accept 7801", 32'(fwd_cnt - f0), 32'h1);
        chk("R4 byte 78", 32'(last_byte), 32'h78);
        f0 = fwd_cnt;
        for (int i = 0; i < 9; i++) send_frame(16'h7801, 1'b1);
        chk("R5 count restarted", 32'(fwd_cnt - f0), 32'h0);
        send_frame(16'h7801, 1'b1);
        chk("R5 refresh after restart", 32'(fwd_cnt - f0), 32'h1);
        chk("R5 refresh byte", 32'(last_byte), 32'h78);

        // R6, R8: silence timeout
        m0 = msg_cnt;
        repeat (TMO - 200) @(posedge clk);
        @(negedge clk);
        chk("R6 no early alarm", 32'(alarm), 32'h0);
        repeat (400) @(posedge clk);
        @(negedge clk);
        chk("R6 timeout alarm", 32'(alarm), 32'h1);
        chk("R8 one message", 32'(msg_cnt - m0), 32'h1);
        repeat (500) @(posedge clk);
        @(negedge clk);
        chk("R8 no repeat message", 32'(msg_cnt - m0), 32'h1);

        // R9: good frame clears
        c0 = clr_cnt;
        send_frame(16'h7801, 1'b1);
        chk("R9 cleared", 32'(alarm), 32'h0);
        chk("R9 clear strobe", 32'(clr_cnt - c0), 32'h1);
        chk("R3 word kept", 32'(status_word), 32'h7801);

        // R2: invalid frames do not restart the timeout
        m0 = msg_cnt;
        for (int i = 0; i < 14; i++) send_frame(16'h7800, 1'b1);
        chk("R2 invalid no restart", 32'(alarm), 32'h1);
        chk("R2 word untouched", 32'(status_word), 32'h7801);
        chk("R8 message on timeout", 32'(msg_cnt - m0), 32'h1);

        c0 = clr_cnt;
        send_frame(16'h7801, 1'b1);
        chk("R9 cleared again", 32'(alarm), 32'h0);
        chk("R9 clear strobe again", 32'(clr_cnt - c0), 32'h1);

        // R7, R8: jumper change
        m0 = msg_cnt;
        @(posedge clk); #1 jumper_in = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R7 jumper alarm", 32'(alarm), 32'h1);
        chk("R8 jumper message", 32'(msg_cnt - m0), 32'h1);
        @(posedge clk); #1 jumper_in = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R8 no message while up", 32'(msg_cnt - m0), 32'h1);
        chk("R7 alarm held", 32'(alarm), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule